// File: doc/BRIEF.md
# Clock-Enable Power State Controller

This block follows the clock-enable pin of a double-data-rate DRAM command interface and decides which power state the device is in. On each rising clock edge it samples clock-enable together with the chip-select, row-strobe, column-strobe and write-enable pins. It compares the clock-enable value against the one from the edge before, so it tracks a falling and a rising transition as a pair. From this it steps through the power-up hold, normal operation, power down and self refresh. It also runs the wait windows that follow a wake-up.

The controller reports its state as a 3-bit code. It raises a one-cycle illegal flag when a command arrives at a time the power rules forbid. It also asks the data and strobe drivers to float while the device sleeps. The bank controller supplies the idle status of every bank as a vector. Bank sequencing itself happens elsewhere.

Top module: `cke_power_ctrl`

## Requirements
- R1: During reset and on the first sample after it, the state code is 0 (power-up hold), the illegal flag is 0 and the float request is 0.
- R2: The power-up hold ends only after PWRUP_CYC consecutive edges on which clock-enable and chip-select are both high. After the last of those edges the state code is 1 (running). After fewer such edges it is still 0.
- R3: If chip-select is low during the power-up hold, the illegal flag rises for one cycle after that edge and the count of stable edges starts over. Clock-enable low during the hold restarts the count without a flag.
- R4: In the running state, an edge with clock-enable low and the refresh encoding (chip-select, row-strobe and column-strobe low, write-enable high) enters self refresh (code 3), provided every bit of the bank-idle vector is 1.
- R5: In the running state, an edge with clock-enable low and a quiet command enters power down (code 2) with no flag, whatever the bank-idle vector holds. A quiet command is chip-select high, or chip-select low with the three strobes high.
- R6: In the running state, an edge with clock-enable low and any other command still enters power down, but it raises the illegal flag. This covers the refresh encoding while any bank is busy.
- R7: While clock-enable stays low, power down and self refresh hold. The float request is 1 exactly when the state code is 2 or 3.
- R8: From power down, an edge with clock-enable high moves to the power-down exit window (code 5). The state becomes 1 after PDX_CYC-1 more edges, so a command is first accepted on the PDX_CYC-th edge after the rising one. A non-quiet command on any edge inside the window raises the illegal flag.
- R9: From self refresh, an edge with clock-enable high and a quiet command moves to the self-refresh exit window (code 4). The state becomes 1 after SRX_CYC-1 more edges, and a non-quiet command inside the window raises the illegal flag.
- R10: A non-quiet command on the edge that leaves self refresh raises the illegal flag, and the controller still enters the exit window.
- R11: In the running state with clock-enable high, every command is accepted without a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock-enable pin |
| cs_n | input | 1 | Chip-select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_idle | input | NUM_BANKS | One bit per bank, 1 when that bank is idle |
| pwr_state | output | 3 | State code: 0 hold, 1 running, 2 power down, 3 self refresh, 4 self-refresh exit, 5 power-down exit |
| illegal | output | 1 | One-cycle flag after an edge that broke a power rule |
| dq_float | output | 1 | Request to float data and strobe drivers |

## Verification
The bench shrinks the timing windows and sweeps the falling edge of clock-enable over all sixteen bank-idle masks and all nine command encodings. This separates refresh entry, quiet power-down entry and flagged entry, and shows that only the all-idle mask lets refresh reach self refresh. After each entry it holds clock-enable low and then counts the edges of the matching exit window, which catches an off-by-one in either window length. Separate sequences put commands at the first and last edge of each window and on the wake-up edge itself. They also restart the power-up count with chip-select low, so a wrong boundary or a missing restart shows up as a state or flag miscompare.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;

   typedef enum logic [2:0] {
      PS_POWERUP   = 3'd0,
      PS_RUN       = 3'd1,
      PS_PDOWN     = 3'd2,
      PS_SREF      = 3'd3,
      PS_SREF_EXIT = 3'd4,
      PS_PD_EXIT   = 3'd5
   } pwr_state_e;

   typedef struct packed {
      logic quiet;    // deselect or no-operation
      logic refresh;  // refresh encoding
   } cmd_class_t;

endpackage

// File: rtl/cke_cmd_classify.sv
module cke_cmd_classify
   import cke_pwr_pkg::*;
(
   input  logic       cs_n,
   input  logic       ras_n,
   input  logic       cas_n,
   input  logic       we_n,
   output cmd_class_t cls
);

   always_comb begin
      cls.quiet   = cs_n | (ras_n & cas_n & we_n);
      cls.refresh = ~cs_n & ~ras_n & ~cas_n & we_n;
   end

endmodule

// File: rtl/cke_window_timer.sv
module cke_window_timer #(
   parameter int unsigned CW      = 8,
   parameter int unsigned RST_VAL = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          dec,
   output logic [CW-1:0] cnt
);

   localparam logic [CW-1:0] RST_CNT = CW'(RST_VAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= RST_CNT;
      else if (load)       cnt <= load_val;
      else if (dec && cnt != '0) cnt <= cnt - 1'b1;
   end

endmodule

// File: rtl/cke_power_ctrl.sv
module cke_power_ctrl
   import cke_pwr_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned PWRUP_CYC = 200,
   parameter int unsigned SRX_CYC   = 200,
   parameter int unsigned PDX_CYC   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cke,
   input  logic                 cs_n,
   input  logic                 ras_n,
   input  logic                 cas_n,
   input  logic                 we_n,
   input  logic [NUM_BANKS-1:0] bank_idle,
   output logic [2:0]           pwr_state,
   output logic                 illegal,
   output logic                 dq_float
);

   localparam int unsigned MAX_A = (PWRUP_CYC > SRX_CYC) ? PWRUP_CYC : SRX_CYC;
   localparam int unsigned MAX_W = (MAX_A > PDX_CYC) ? MAX_A : PDX_CYC;
   localparam int unsigned CW    = $clog2(MAX_W) + 1;
   localparam logic [CW-1:0] PWRUP_LD = CW'(PWRUP_CYC - 1);
   localparam logic [CW-1:0] SRX_LD   = CW'(SRX_CYC - 1);
   localparam logic [CW-1:0] PDX_LD   = CW'(PDX_CYC - 1);
   localparam logic [CW-1:0] ONE      = CW'(1);

   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("NUM_BANKS must be at least 1");
   end
   if (PWRUP_CYC < 1) begin : g_bad_pwrup
      $error("PWRUP_CYC must be at least 1");
   end
   if (SRX_CYC < 2 || PDX_CYC < 2) begin : g_bad_exit
      $error("exit windows must be at least 2 cycles");
   end

   // ---------------------------------------------------------------
   // Inputs
   // ---------------------------------------------------------------
   cmd_class_t cls;
   logic       all_idle;
   logic       cke_q;

   cke_cmd_classify u_cls (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cls   (cls)
   );

   if (NUM_BANKS == 1) begin : g_idle_one
      assign all_idle = bank_idle[0];
   end else begin : g_idle_many
      assign all_idle = &bank_idle;
   end

   // ---------------------------------------------------------------
   // State and shared window counter
   // ---------------------------------------------------------------
   pwr_state_e      st_q, st_d;
   logic            ill_d, ill_q;
   logic            t_load, t_dec;
   logic [CW-1:0]   t_val;
   logic [CW-1:0]   t_cnt;

   cke_window_timer #(.CW(CW), .RST_VAL(PWRUP_CYC - 1)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .dec      (t_dec),
      .cnt      (t_cnt)
   );

   always_comb begin
      st_d   = st_q;
      ill_d  = 1'b0;
      t_load = 1'b0;
      t_dec  = 1'b0;
      t_val  = PWRUP_LD;
      unique case (st_q)
         PS_POWERUP: begin
            if (cke && cs_n) begin
               if (t_cnt == '0) st_d = PS_RUN;
               else             t_dec = 1'b1;
            end else begin
               t_load = 1'b1;
               t_val  = PWRUP_LD;
               ill_d  = ~cs_n;
            end
         end
         PS_RUN: begin
            if (!cke) begin
               if (cls.refresh && all_idle) begin
                  st_d = PS_SREF;
               end else begin
                  st_d  = PS_PDOWN;
                  ill_d = ~cls.quiet;
               end
            end
         end
         PS_PDOWN: begin
            if (!cke_q && cke) begin
               st_d   = PS_PD_EXIT;
               t_load = 1'b1;
               t_val  = PDX_LD;
               ill_d  = ~cls.quiet;
            end
         end
         PS_SREF: begin
            if (!cke_q && cke) begin
               st_d   = PS_SREF_EXIT;
               t_load = 1'b1;
               t_val  = SRX_LD;
               ill_d  = ~cls.quiet;
            end
         end
         PS_SREF_EXIT, PS_PD_EXIT: begin
            ill_d = ~cls.quiet;
            if (t_cnt == ONE) st_d = PS_RUN;
            else              t_dec = 1'b1;
         end
         default: st_d = PS_POWERUP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= PS_POWERUP;
         ill_q <= 1'b0;
         cke_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         ill_q <= ill_d;
         cke_q <= cke;
      end
   end

   assign pwr_state = st_q;
   assign illegal   = ill_q;
   assign dq_float  = (st_q == PS_PDOWN) || (st_q == PS_SREF);

   // ---------------------------------------------------------------
   // Assertions
   // ---------------------------------------------------------------
   // R2
   hold_exit_only_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_POWERUP) |=> (st_q == PS_POWERUP || st_q == PS_RUN));

   // R4
   sref_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_RUN && !cke && !all_idle) |=> (st_q != PS_SREF));

   // R5
   run_cke_low_sleeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_RUN && !cke) |=> (st_q == PS_PDOWN || st_q == PS_SREF));

   // R7
   float_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_float |-> !cke_q);

   // R9
   srx_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_SREF_EXIT) |=> (st_q == PS_SREF_EXIT || st_q == PS_RUN));

   // R8
   pdx_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_PD_EXIT) |=> (st_q == PS_PD_EXIT || st_q == PS_RUN));

   // R11
   run_high_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_RUN && cke) |=> !illegal);

endmodule

// File: tb/tb_cke_power_ctrl.sv
module tb_cke_power_ctrl;

   localparam int NB    = 4;
   localparam int PWRUP = 8;
   localparam int SRX   = 5;
   localparam int PDX   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [NB-1:0] bank_idle = '1;
   logic [2:0] pwr_state;
   logic illegal, dq_float;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   cke_power_ctrl #(.NUM_BANKS(NB), .PWRUP_CYC(PWRUP), .SRX_CYC(SRX), .PDX_CYC(PDX)) dut (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .bank_idle(bank_idle),
      .pwr_state(pwr_state), .illegal(illegal), .dq_float(dq_float)
   );

   // command codes: 0 deselect, 1 no-op, 2 refresh, 3 activate, 4 read,
   // 5 write, 6 precharge, 7 mode set, 8 burst stop
   function automatic logic [3:0] enc(input int c);
      case (c)
         0: enc = 4'b1111;
         1: enc = 4'b0111;
         2: enc = 4'b0001;
         3: enc = 4'b0011;
         4: enc = 4'b0101;
         5: enc = 4'b0100;
         6: enc = 4'b0010;
         7: enc = 4'b0000;
         default: enc = 4'b0110;
      endcase
   endfunction

   // drive at a falling edge, let one rising edge pass, return at the next falling edge
   task automatic step(input logic k, input int c);
      logic [3:0] e;
      e = enc(c);
      cke = k; cs_n = e[3]; ras_n = e[2]; cas_n = e[1]; we_n = e[0];
      @(negedge clk);
   endtask

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic wake_from(input int st);
      int n;
      step(1'b1, 0);
      chk("R8/R9 exit state", pwr_state, (st == 2) ? 5 : 4);
      chk("R7 float off", dq_float, 0);
      n = (st == 2) ? PDX - 1 : SRX - 1;
      for (int i = 1; i <= n; i++) begin
         step(1'b1, 0);
         chk("R8/R9 window length", pwr_state, (i == n) ? 1 : ((st == 2) ? 5 : 4));
      end
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      @(negedge clk);
      // R1
      chk("R1 state", pwr_state, 0);
      chk("R1 illegal", illegal, 0);
      chk("R1 float", dq_float, 0);
      rst_n = 1'b1;
      step(1'b1, 0);
      chk("R1 state after release", pwr_state, 0);

      // R3: chip-select low restarts the count
      step(1'b1, 0);
      step(1'b1, 1);
      chk("R3 flag", illegal, 1);
      chk("R3 state", pwr_state, 0);
      step(1'b0, 0);
      chk("R3 cke low no flag", illegal, 0);
      // R2
      for (int i = 1; i <= PWRUP; i++) begin
         step(1'b1, 0);
         chk("R2 hold count", pwr_state, (i == PWRUP) ? 1 : 0);
      end

      // R11
      for (int c = 0; c <= 8; c++) begin
         step(1'b1, c);
         chk("R11 no flag", illegal, 0);
         chk("R11 running", pwr_state, 1);
      end

      // sweep entry: R4 R5 R6 R7
      for (int m = 0; m < 16; m++) begin
         for (int c = 0; c <= 8; c++) begin
            int est, eill;
            bank_idle = 4'(m);
            if (c <= 1)                  begin est = 2; eill = 0; end
            else if (c == 2 && m == 15)  begin est = 3; eill = 0; end
            else                         begin est = 2; eill = 1; end
            step(1'b0, c);
            chk((est == 3) ? "R4 entry state" : (eill ? "R6 entry state" : "R5 entry state"), pwr_state, est);
            chk(eill ? "R6 flag" : "R5 flag", illegal, eill);
            chk("R7 float on", dq_float, 1);
            step(1'b0, 0);
            chk("R7 hold low", pwr_state, est);
            chk("R7 flag clear", illegal, 0);
            chk("R7 float held", dq_float, 1);
            wake_from(est);
         end
      end
      bank_idle = '1;

      // R8 command in the power-down window
      step(1'b0, 0);
      step(1'b1, 0);
      step(1'b1, 4);
      chk("R8 first window edge flag", illegal, 1);
      step(1'b1, 5);
      chk("R8 last window edge flag", illegal, 1);
      chk("R8 running after window", pwr_state, 1);
      step(1'b1, 4);
      chk("R8 accepted after window", illegal, 0);

      // R10 and R9
      step(1'b0, 2);
      chk("R4 self refresh", pwr_state, 3);
      step(1'b1, 3);
      chk("R10 flag on exit edge", illegal, 1);
      chk("R10 still exits", pwr_state, 4);
      step(1'b1, 0);
      chk("R9 quiet in window", illegal, 0);
      step(1'b1, 6);
      chk("R9 command in window", illegal, 1);
      step(1'b1, 0);
      step(1'b1, 0);
      chk("R9 running", pwr_state, 1);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule